// File: doc/BRIEF.md
# Per-Port Event Interrupt Collector

This block gathers one-cycle event pulses from a set of serial line ports and turns them into one interrupt line for the CPU. Each port raises four kinds of event: monitor-channel receive, monitor-channel transmit, command/indication receive and command/indication transmit. Each event sets a sticky pending bit. The CPU reads the whole set of pending bits as a flat status vector. That vector holds one group of four bits per port. Inside each group the order is monitor receive, monitor transmit, command/indication receive, command/indication transmit.

No write to the status vector clears a pending bit. A bit clears when the CPU accesses the channel data register that belongs to that port and event kind. The access is reported to the block as a strobe with a port number, a source code and a read/write flag. Receive registers clear their bit only when they are read. Transmit registers clear their bit on either a read or a write.

There are two kinds of mask: one bit per port and one bit per pending bit. Masks only gate the interrupt output, never the capture of events. The interrupt output is a registered OR of every pending bit that is not masked.

Top module: `port_event_irq_ctrl`

## Requirements
- R1: While the active-low reset is asserted, `rawStatus` is all zeros and `irqOut` is 0.
- R2: An `evtIn` pulse at bit `p*4+s` sets `rawStatus[p*4+s]` at the next clock edge. Source codes are: s=0 monitor receive, s=1 monitor transmit, s=2 command/indication receive, s=3 command/indication transmit. The bit then holds until it is cleared.
- R3: A read access (`accWrite`=0) with `accPort`=p and `accSrc`=s clears the bit at the next edge when s is 0 or 2. A write access to s=0 or s=2 leaves the bit unchanged.
- R4: For s=1 or s=3, the addressed bit clears at the next edge on either a read or a write access.
- R5: An access clears only the one bit at index `accPort*4+accSrc`. Every other pending bit is left unchanged.
- R6: If an event and a clearing access hit the same bit in the same cycle, the bit stays set.
- R7: A bit with its `srcMask` bit at 1 is still latched in `rawStatus`, but it does not drive `irqOut`.
- R8: `portMask[p]`=1 stops all four bits of port p from driving `irqOut`. Those bits stay visible in `rawStatus`.
- R9: If a masked bit is still pending when its mask is cleared, `irqOut` rises one cycle after the mask changes.
- R10: `irqOut` in cycle t+1 equals the OR, over all bits, of pending AND not masked, as sampled in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_PORTS*4 | Event pulses, bit p*4+s |
| accValid | input | 1 | CPU accessed a channel data register this cycle |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accPort | input | $clog2(NUM_PORTS) | Port of the accessed register |
| accSrc | input | 2 | Source code of the accessed register (0..3 as in R2) |
| portMask | input | NUM_PORTS | 1 masks the whole port |
| srcMask | input | NUM_PORTS*4 | 1 masks that single pending bit |
| rawStatus | output | NUM_PORTS*4 | Pending bits before masking |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its default of four ports. This gives a 16-bit status vector and a 2-bit port field. With that field every pair of port number and source code maps onto a real bit, so clears at both ends of the vector can be reached. Directed sequences cover the following:
- read versus write clears on receive and transmit sources;
- an event landing in the same cycle as its clear;
- per-bit and per-port masking, including unmasking while an event is still pending.

A long pseudo-random phase then mixes sparse events, accesses and mask changes. A behavioural model is compared against the status vector and the interrupt line on every cycle.

// File: rtl/port_event_irq_pkg.sv
package port_event_irq_pkg;

  localparam int SRC_CNT = 4;
  localparam int IDX_W   = 8;

  typedef enum logic [1:0] {
    SRC_MON_RX = 2'd0,
    SRC_MON_TX = 2'd1,
    SRC_CI_RX  = 2'd2,
    SRC_CI_TX  = 2'd3
  } evtSrc_e;

  typedef struct packed {
    logic             clrFire;
    logic [IDX_W-1:0] clrIdx;
  } clrStrobe_t;

  function automatic logic writeMayClear(input logic [1:0] src);
    return (evtSrc_e'(src) == SRC_MON_TX) || (evtSrc_e'(src) == SRC_CI_TX);
  endfunction

endpackage

// File: rtl/port_event_irq_ctl.sv
module port_event_irq_ctl
  import port_event_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [PORT_W-1:0] accPort,
  input  logic [1:0]        accSrc,
  output clrStrobe_t        strobes
);

  always_comb begin
    strobes.clrIdx  = IDX_W'({accPort, accSrc});
    strobes.clrFire = accValid && (!accWrite || writeMayClear(accSrc));
  end

endmodule

// File: rtl/port_event_irq_dp.sv
module port_event_irq_dp
  import port_event_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int STAT_W = NUM_PORTS * SRC_CNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STAT_W-1:0]    evtIn,
  input  clrStrobe_t           strobes,
  input  logic [NUM_PORTS-1:0] portMask,
  input  logic [STAT_W-1:0]    srcMask,
  output logic [STAT_W-1:0]    pendQ,
  output logic                 irqQ
);

  logic [STAT_W-1:0] clrHit;
  logic [STAT_W-1:0] enableVec;
  logic [STAT_W-1:0] pendNext;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    assign clrHit[i]    = strobes.clrFire && (strobes.clrIdx == IDX_W'(i));
    assign enableVec[i] = !portMask[i / SRC_CNT] && !srcMask[i];
  end

  assign pendNext = (pendQ & ~clrHit) | evtIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      pendQ <= pendNext;
      irqQ  <= |(pendQ & enableVec);
    end
  end

endmodule

// File: rtl/port_event_irq_ctrl.sv
module port_event_irq_ctrl
  import port_event_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int STAT_W = NUM_PORTS * SRC_CNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STAT_W-1:0]    evtIn,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic [PORT_W-1:0]    accPort,
  input  logic [1:0]           accSrc,
  input  logic [NUM_PORTS-1:0] portMask,
  input  logic [STAT_W-1:0]    srcMask,
  output logic [STAT_W-1:0]    rawStatus,
  output logic                 irqOut
);

  clrStrobe_t strobes;

  port_event_irq_ctl #(.NUM_PORTS(NUM_PORTS)) ctl_i (
    .accValid (accValid),
    .accWrite (accWrite),
    .accPort  (accPort),
    .accSrc   (accSrc),
    .strobes  (strobes)
  );

  port_event_irq_dp #(.NUM_PORTS(NUM_PORTS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .evtIn    (evtIn),
    .strobes  (strobes),
    .portMask (portMask),
    .srcMask  (srcMask),
    .pendQ    (rawStatus),
    .irqQ     (irqOut)
  );

endmodule

// File: rtl/port_event_irq_chk.sv
module port_event_irq_chk #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int STAT_W = NUM_PORTS * 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [STAT_W-1:0]    evtIn,
  input logic                 accValid,
  input logic                 accWrite,
  input logic [PORT_W-1:0]    accPort,
  input logic [1:0]           accSrc,
  input logic [NUM_PORTS-1:0] portMask,
  input logic [STAT_W-1:0]    srcMask,
  input logic [STAT_W-1:0]    rawStatus,
  input logic                 irqOut
);

  logic [PORT_W+1:0] aIdx;
  logic [STAT_W-1:0] liveVec;

  assign aIdx = {accPort, accSrc};

  always_comb begin
    for (int i = 0; i < STAT_W; i++) begin
      liveVec[i] = rawStatus[i] && !srcMask[i] && !portMask[i / 4];
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (rawStatus == '0 && !irqOut)); // R1

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((rawStatus & $past(evtIn)) == $past(evtIn))); // R2

  AST_RX_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && !accSrc[0] && rawStatus[aIdx]) |=> rawStatus[$past(aIdx)]); // R3

  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (!accWrite || accSrc[0]) && !evtIn[aIdx]) |=> !rawStatus[$past(aIdx)]); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (liveVec == '0) |=> !irqOut); // R7

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (liveVec != '0) |=> irqOut); // R10

endmodule

bind port_event_irq_ctrl port_event_irq_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (.*);

// File: tb/port_event_irq_ctrl_tb_top.sv
module port_event_irq_ctrl_tb_top;

  localparam int NP = 4;
  localparam int SW = NP * 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b1;
  logic [SW-1:0] evtIn = '0;
  logic          accValid = 1'b0;
  logic          accWrite = 1'b0;
  logic [1:0]    accPort = '0;
  logic [1:0]    accSrc = '0;
  logic [NP-1:0] portMask = '0;
  logic [SW-1:0] srcMask = '0;
  logic [SW-1:0] rawStatus;
  logic          irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit autoCmp = 0;

  bit [SW-1:0] mPend = '0;
  bit          mIrq = 1'b0;
  int unsigned lfsr = 32'h1ACE_0F17;

  always #4 clk = ~clk;

  port_event_irq_ctrl #(.NUM_PORTS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .accValid(accValid),
    .accWrite(accWrite), .accPort(accPort), .accSrc(accSrc),
    .portMask(portMask), .srcMask(srcMask), .rawStatus(rawStatus),
    .irqOut(irqOut)
  );

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0;
      mIrq  = 1'b0;
    end else begin
      bit live;
      int target;
      live = 1'b0;
      for (int p = 0; p < NP; p++)
        for (int s = 0; s < 4; s++)
          if (mPend[p*4+s] && !portMask[p] && !srcMask[p*4+s]) live = 1'b1;
      target = int'(accPort) * 4 + int'(accSrc);
      if (accValid && (!accWrite || accSrc == 2'd1 || accSrc == 2'd3))
        mPend[target] = 1'b0;
      mPend = mPend | evtIn;
      mIrq  = live;
    end
  end

  always @(posedge clk) begin
    #2;
    if (autoCmp && !finished) begin
      checks++;
      if (rawStatus !== mPend) begin
        failures++;
        $display("FAIL R2 R5 rawStatus act=%h exp=%h", rawStatus, mPend);
      end
      checks++;
      if (irqOut !== mIrq) begin
        failures++;
        $display("FAIL R10 irqOut act=%b exp=%b", irqOut, mIrq);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [SW-1:0] e, input logic av, input logic aw,
                       input int p, input int s);
    @(negedge clk);
    evtIn = e; accValid = av; accWrite = aw;
    accPort = 2'(p); accSrc = 2'(s);
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    drive('0, 1'b0, 1'b0, 0, 0);
    settle();
  endtask

  function automatic int unsigned nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    #1 rstN = 1'b0;
    settle();
    check("R1 rawStatus", 32'(rawStatus), 32'h0);
    check("R1 irqOut", 32'(irqOut), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    autoCmp = 1;

    // R2: port 2 monitor receive -> bit 8
    drive(16'h0100, 1'b0, 1'b0, 0, 0); settle();
    check("R2 set", 32'(rawStatus), 32'h0100);
    check("R10 latency", 32'(irqOut), 32'h0);
    idle();
    check("R10 raised", 32'(irqOut), 32'h1);

    // R3: write to a receive register keeps the bit, read clears it
    drive('0, 1'b1, 1'b1, 2, 0); settle();
    check("R3 write keeps", 32'(rawStatus), 32'h0100);
    drive('0, 1'b1, 1'b0, 2, 0); settle();
    check("R3 read clears", 32'(rawStatus), 32'h0);
    idle();
    check("R10 drop", 32'(irqOut), 32'h0);

    // R4 R5: write clears a transmit bit, leaves others
    drive(16'h8020, 1'b0, 1'b0, 0, 0); settle();
    drive('0, 1'b1, 1'b1, 1, 1); settle();
    check("R4 R5 tx write clear", 32'(rawStatus), 32'h8000);
    drive(16'h0040, 1'b0, 1'b0, 0, 0); settle();
    drive('0, 1'b1, 1'b1, 1, 2); settle();
    check("R3 ci rx write keeps", 32'(rawStatus), 32'h8040);
    drive('0, 1'b1, 1'b0, 1, 2); settle();
    check("R3 ci rx read clears", 32'(rawStatus), 32'h8000);

    // R6: event and clear on the same bit
    drive(16'h8000, 1'b1, 1'b0, 3, 3); settle();
    check("R6 event wins", 32'(rawStatus), 32'h8000);
    drive('0, 1'b1, 1'b0, 3, 3); settle();
    check("R4 tx read clear", 32'(rawStatus), 32'h0);
    idle(); idle();

    // R7 R9: per-bit mask
    @(negedge clk); srcMask = 16'h0004;
    drive(16'h0004, 1'b0, 1'b0, 0, 0); settle();
    check("R7 latched", 32'(rawStatus), 32'h0004);
    idle(); idle();
    check("R7 masked irq", 32'(irqOut), 32'h0);
    @(negedge clk); srcMask = '0;
    settle();
    check("R9 unmask raises", 32'(irqOut), 32'h1);

    // R8: port mask
    @(negedge clk); portMask = 4'b0001;
    drive(16'h000F, 1'b0, 1'b0, 0, 0); settle();
    idle();
    check("R8 port latched", 32'(rawStatus), 32'h000F);
    check("R8 port masked", 32'(irqOut), 32'h0);
    @(negedge clk); portMask = 4'b0000;
    settle();
    check("R9 port unmask", 32'(irqOut), 32'h1);
    for (int s = 0; s < 4; s++) begin
      drive('0, 1'b1, 1'b0, 0, s); settle();
    end
    check("R5 all cleared", 32'(rawStatus), 32'h0);

    // mixed traffic, compared against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [SW-1:0] e;
      int unsigned r;
      r = nextRand();
      e = SW'(nextRand() & nextRand() & nextRand());
      drive(e, r[0], r[1], int'(r[3:2]), int'(r[5:4]));
      if (r[11:8] == 4'd0) begin
        portMask = NP'(nextRand());
        srcMask  = SW'(nextRand() & nextRand());
      end
    end
    idle(); idle();
    finish_run();
  end

endmodule